// File: doc/BRIEF.md
# Receive Frame Byte Tracker

This block sits on the MAC side of a byte-wide PHY receive path. The PHY presents each received byte on `data`, marked valid by `data_en`. The PHY sends no marker for where the status bytes begin, so the tracker finds every field by counting bytes.

A frame begins with a physical-layer header. The tracker takes the data rate and the 12-bit length from this header. It then skips the MAC header and captures the error code from the header status byte. Next it strobes out the payload and FCS bytes. Finally it captures the three trailing status bytes: signal strength, link quality and receive error code. A one-cycle done pulse marks the end of the frame.

When the MAC drops `rx_en` part way through a frame, counting stops. The tracker then waits until `phy_active` is low and no byte has been delivered for a fixed number of cycles. The last three bytes delivered before that point are taken as the status bytes.

Top module: `mac_rx_frame_tracker`

## Requirements
- R1: While reset is held (active-low `rst_n`), and after it is released, every output is zero until the first byte is accepted.
- R2: A byte is accepted on a rising clock edge only when `data_en` is high. On any other edge, `data` has no effect on any output.
- R3: Bytes are numbered from 0 within a frame. `frm_rate` takes bits 4:0 of byte 0. `frm_len` takes byte 1 as bits 7:0 and bits 3:0 of byte 2 as bits 11:8.
- R4: `hdr_err` takes bits 4:0 of byte 16. Bytes 3 to 15 change no output.
- R5: For a length L, each byte numbered 17 to 16+L raises `pay_stb` for one cycle after its edge, with that byte on `pay_data`. No other byte raises `pay_stb`.
- R6: Byte 17+L is loaded into `rssi` and byte 18+L into `lqi`. Bits 4:0 of byte 19+L are loaded into `rx_err`. This placement does not depend on `phy_active`.
- R7: When L is zero, the status bytes are bytes 17, 18 and 19, and `pay_stb` never rises.
- R8: `frm_done` is high for exactly the one cycle after the final status byte is accepted. The next accepted byte is byte 0 of a new frame.
- R9: Low `rx_en` during a frame aborts it. From then on no byte raises `pay_stb`, and the count does not end the frame. Low `rx_en` outside a frame has no effect.
- R10: An aborted frame ends with `frm_done` once QUIET_CYC consecutive edges have passed with both `phy_active` and `data_en` low. At that point `rssi`, `lqi` and `rx_err` take the third-last, second-last and last bytes delivered, the last one through bits 4:0. A byte delivered, or `phy_active` high, restarts the quiet count.
- R11: `frm_aborted` reads 1 with an aborted frame's done pulse and 0 with a counted frame's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | MAC receive enable; low during a frame aborts it |
| phy_active | input | 1 | PHY frame-activity indication |
| data_en | input | 1 | Byte qualifier from the PHY |
| data | input | 8 | Received byte |
| frm_len | output | LEN_W | Frame length from header |
| frm_rate | output | 5 | Rate field from header |
| hdr_err | output | 5 | Header error code |
| pay_stb | output | 1 | Payload/FCS byte strobe |
| pay_data | output | 8 | Payload/FCS byte |
| rssi | output | 8 | Signal strength status byte |
| lqi | output | 8 | Link quality status byte |
| rx_err | output | 5 | Receive error code |
| frm_done | output | 1 | One-cycle end-of-frame pulse |
| frm_aborted | output | 1 | Frame ended by MAC abort |

## Verification
Some properties are checked by assertions on every cycle. These cover the following:
- the done pulse lasts one cycle and leaves the tracker outside a frame;
- the byte index never passes the last status position of a counted frame;
- an abort only exists inside a frame;
- an aborted frame completes only after a quiet edge;
- a zero-length frame never strobes payload.

Other properties only the bench scenarios can show. These are the field values extracted under random idle gaps, and the exact payload strobe window for many lengths, including a length with a non-zero high nibble. They also include the choice of the last three bytes on abort, with and without an interrupted quiet period, and the fact that `rx_en` low outside a frame is ignored.

// File: rtl/mrft_pkg.sv
package mrft_pkg;
  localparam int unsigned IDX_RATE     = 0;
  localparam int unsigned IDX_LEN_LO   = 1;
  localparam int unsigned IDX_LEN_HI   = 2;
  localparam int unsigned IDX_HDR_STAT = 16;
  localparam int unsigned N_STAT       = 3;
  localparam int unsigned CODE_W       = 5;

  // index of the first trailing status byte for a given length
  function automatic int unsigned stat_first(input int unsigned len);
    return IDX_HDR_STAT + 1 + len;
  endfunction

  // index of the final (error code) status byte
  function automatic int unsigned stat_last(input int unsigned len);
    return stat_first(len) + N_STAT - 1;
  endfunction
endpackage

// File: rtl/rxt_byte_counter.sv
module rxt_byte_counter #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_en,
  input  logic             frame_end,
  input  logic             abort_q,
  input  logic [LEN_W-1:0] len_q,
  output logic             accept,
  output logic             in_frame,
  output logic [CNT_W-1:0] cur_idx
);
  import mrft_pkg::*;

  logic [CNT_W-1:0] idx_q;

  assign accept  = data_en;
  assign cur_idx = in_frame ? idx_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idx_q    <= '0;
    end else if (frame_end) begin
      in_frame <= 1'b0;
      idx_q    <= '0;
    end else if (accept) begin
      in_frame <= 1'b1;
      idx_q    <= cur_idx + 1'b1;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !abort_q) |-> (idx_q <= CNT_W'(stat_last(32'(len_q))))) else $error("idx past status"); // R6
endmodule

// File: rtl/rxt_abort_ctl.sv
module rxt_abort_ctl #(
  parameter int QUIET_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_frame,
  input  logic normal_end,
  input  logic rx_en,
  input  logic phy_active,
  input  logic data_en,
  output logic abort_q,
  output logic abort_done
);
  localparam int QW = $clog2(QUIET_CYC + 1);

  logic          quiet;
  logic [QW-1:0] qcnt;

  assign quiet      = !phy_active && !data_en;
  assign abort_done = abort_q && quiet && (qcnt == QW'(QUIET_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      qcnt    <= '0;
    end else if (abort_done) begin
      abort_q <= 1'b0;
      qcnt    <= '0;
    end else begin
      if (in_frame && !rx_en && !normal_end) abort_q <= 1'b1;
      if (abort_q) qcnt <= quiet ? qcnt + 1'b1 : '0;
    end
  end

  AST_ABORT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> in_frame) else $error("abort outside frame"); // R9
endmodule

// File: rtl/rxt_field_capture.sv
module rxt_field_capture #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic [CNT_W-1:0]              cur_idx,
  input  logic [7:0]                    data,
  input  logic                          abort_q,
  input  logic                          abort_done,
  output logic                          normal_end,
  output logic [LEN_W-1:0]              len_q,
  output logic [mrft_pkg::CODE_W-1:0]   rate_q,
  output logic [mrft_pkg::CODE_W-1:0]   hdr_err_q,
  output logic                          pay_stb_q,
  output logic [7:0]                    pay_data_q,
  output logic [7:0]                    rssi_q,
  output logic [7:0]                    lqi_q,
  output logic [mrft_pkg::CODE_W-1:0]   rx_err_q,
  output logic                          done_q,
  output logic                          aborted_q
);
  import mrft_pkg::*;

  localparam int HI_W = LEN_W - 8;

  logic [CNT_W-1:0] base_idx;
  logic             counted;
  logic             is_pay;
  logic [7:0]       sb [N_STAT];

  assign base_idx   = CNT_W'(stat_first(32'(len_q)));
  assign counted    = accept && !abort_q;
  assign is_pay     = counted && (cur_idx > CNT_W'(IDX_HDR_STAT)) && (cur_idx < base_idx);
  assign normal_end = counted && (cur_idx == base_idx + CNT_W'(N_STAT - 1));

  // history of the most recent bytes, sb[0] newest
  always_ff @(posedge clk) begin
    if (!rst_n) sb[0] <= '0;
    else if (accept) sb[0] <= data;
  end
  for (genvar g = 1; g < N_STAT; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) sb[g] <= '0;
      else if (accept) sb[g] <= sb[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q      <= '0;
      rate_q     <= '0;
      hdr_err_q  <= '0;
      pay_stb_q  <= 1'b0;
      pay_data_q <= '0;
      rssi_q     <= '0;
      lqi_q      <= '0;
      rx_err_q   <= '0;
      done_q     <= 1'b0;
      aborted_q  <= 1'b0;
    end else begin
      pay_stb_q <= is_pay;
      done_q    <= normal_end || abort_done;
      if (is_pay) pay_data_q <= data;
      if (accept) begin
        if (cur_idx == CNT_W'(IDX_RATE))     rate_q            <= data[CODE_W-1:0];
        if (cur_idx == CNT_W'(IDX_LEN_LO))   len_q[7:0]        <= data;
        if (cur_idx == CNT_W'(IDX_LEN_HI))   len_q[LEN_W-1:8]  <= data[HI_W-1:0];
        if (cur_idx == CNT_W'(IDX_HDR_STAT)) hdr_err_q         <= data[CODE_W-1:0];
      end
      if (counted && cur_idx == base_idx)              rssi_q <= data;
      if (counted && cur_idx == base_idx + 1'b1)       lqi_q  <= data;
      if (normal_end) begin
        rx_err_q  <= data[CODE_W-1:0];
        aborted_q <= 1'b0;
      end
      if (abort_done) begin
        rssi_q    <= sb[2];
        lqi_q     <= sb[1];
        rx_err_q  <= sb[0][CODE_W-1:0];
        aborted_q <= 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8
endmodule

// File: rtl/mac_rx_frame_tracker.sv
module mac_rx_frame_tracker #(
  parameter int LEN_W     = 12,
  parameter int QUIET_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             phy_active,
  input  logic             data_en,
  input  logic [7:0]       data,
  output logic [LEN_W-1:0] frm_len,
  output logic [4:0]       frm_rate,
  output logic [4:0]       hdr_err,
  output logic             pay_stb,
  output logic [7:0]       pay_data,
  output logic [7:0]       rssi,
  output logic [7:0]       lqi,
  output logic [4:0]       rx_err,
  output logic             frm_done,
  output logic             frm_aborted
);
  localparam int CNT_W = LEN_W + 2;

  // named internal events
  logic             accept;
  logic             in_frame;
  logic [CNT_W-1:0] cur_idx;
  logic             normal_end;
  logic             abort_q;
  logic             abort_done;
  logic             frame_end;

  assign frame_end = normal_end || abort_done;

  rxt_byte_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .data_en(data_en), .frame_end(frame_end),
    .abort_q(abort_q), .len_q(frm_len), .accept(accept),
    .in_frame(in_frame), .cur_idx(cur_idx)
  );

  rxt_abort_ctl #(.QUIET_CYC(QUIET_CYC)) u_abort (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .normal_end(normal_end),
    .rx_en(rx_en), .phy_active(phy_active), .data_en(data_en),
    .abort_q(abort_q), .abort_done(abort_done)
  );

  rxt_field_capture #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cur_idx(cur_idx), .data(data),
    .abort_q(abort_q), .abort_done(abort_done), .normal_end(normal_end),
    .len_q(frm_len), .rate_q(frm_rate), .hdr_err_q(hdr_err),
    .pay_stb_q(pay_stb), .pay_data_q(pay_data), .rssi_q(rssi), .lqi_q(lqi),
    .rx_err_q(rx_err), .done_q(frm_done), .aborted_q(frm_aborted)
  );

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> !in_frame) else $error("done while in frame"); // R8
  AST_ZERO_LEN_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    pay_stb |-> (frm_len != '0)) else $error("strobe on zero length"); // R7
  AST_ABORT_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_aborted) |-> $past(!phy_active && !data_en)) else $error("abort done not quiet"); // R10
endmodule

// File: tb/mac_rx_frame_tracker_tb_top.sv
module mac_rx_frame_tracker_tb_top;
  localparam int QUIET = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1, phy_active = 1'b0, data_en = 1'b0;
  logic [7:0] data = '0;
  logic [11:0] frm_len;
  logic [4:0] frm_rate, hdr_err, rx_err;
  logic pay_stb, frm_done, frm_aborted;
  logic [7:0] pay_data, rssi, lqi;

  int n_chk = 0, n_bad = 0;
  logic [7:0] fb [0:511];
  logic [7:0] h0, h1, h2; // last three delivered, h0 newest

  always #4 clk = ~clk;

  mac_rx_frame_tracker #(.LEN_W(12), .QUIET_CYC(QUIET)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .phy_active(phy_active),
    .data_en(data_en), .data(data), .frm_len(frm_len), .frm_rate(frm_rate),
    .hdr_err(hdr_err), .pay_stb(pay_stb), .pay_data(pay_data), .rssi(rssi),
    .lqi(lqi), .rx_err(rx_err), .frm_done(frm_done), .frm_aborted(frm_aborted)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int first_stat(input int len);
    return 17 + len; // R6 placement restated
  endfunction

  task automatic put(input bit en, input logic [7:0] b);
    data_en = en;
    data = en ? b : 8'($urandom);
    if (en) begin h2 = h1; h1 = h0; h0 = b; end
    @(negedge clk);
  endtask

  task automatic build(input int len);
    for (int i = 0; i < 20 + len; i++) fb[i] = 8'($urandom);
    fb[1] = len[7:0];
    fb[2] = {4'($urandom), len[11:8]};
  endtask

  task automatic idle_check(input string req);
    put(1'b0, 8'h00);
    chk(pay_stb == 1'b0, req, 32'(pay_stb), 0);
    chk(frm_done == 1'b0, req, 32'(frm_done), 0);
  endtask

  task automatic send_frame(input int len, input int gapmax);
    int total = 20 + len;
    build(len);
    phy_active = 1'b1;
    for (int i = 0; i < total; i++) begin
      int gaps = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
      repeat (gaps) idle_check("R2");
      if (i >= first_stat(len)) phy_active = 1'b0; // R6 status after activity ends
      put(1'b1, fb[i]);
      begin
        bit exp_pay = (i >= 17) && (i < first_stat(len));
        chk(pay_stb == exp_pay, (len == 0) ? "R7" : "R5", 32'(pay_stb), 32'(exp_pay));
        if (exp_pay) chk(pay_data == fb[i], "R5", 32'(pay_data), 32'(fb[i]));
      end
      if (i != total - 1) begin
        if (i % 8 == 0) chk(frm_done == 1'b0, "R8", 32'(frm_done), 0);
      end else begin
        chk(frm_done == 1'b1, "R8", 32'(frm_done), 1);
        chk(frm_rate == fb[0][4:0], "R3", 32'(frm_rate), 32'(fb[0][4:0]));
        chk(frm_len == 12'(len), "R3", 32'(frm_len), 32'(len));
        chk(hdr_err == fb[16][4:0], "R4", 32'(hdr_err), 32'(fb[16][4:0]));
        chk(rssi == fb[len+17], "R6", 32'(rssi), 32'(fb[len+17]));
        chk(lqi == fb[len+18], "R6", 32'(lqi), 32'(fb[len+18]));
        chk(rx_err == fb[len+19][4:0], "R6", 32'(rx_err), 32'(fb[len+19][4:0]));
        chk(frm_aborted == 1'b0, "R11", 32'(frm_aborted), 0);
      end
    end
    data_en = 1'b0;
    idle_check("R8");
  endtask

  task automatic send_abort(input int len, input int k, input int extra, input bit interrupt);
    build(len);
    phy_active = 1'b1;
    for (int i = 0; i < k; i++) put(1'b1, fb[i]);
    rx_en = 1'b0;
    idle_check("R9");
    phy_active = 1'b0;
    for (int i = 0; i < extra; i++) begin
      put(1'b1, 8'($urandom));
      chk(pay_stb == 1'b0, "R9", 32'(pay_stb), 0);
    end
    if (interrupt) begin
      idle_check("R10");
      idle_check("R10");
      put(1'b1, 8'($urandom));
    end
    for (int q = 1; q <= QUIET; q++) begin
      put(1'b0, 8'h00);
      chk(frm_done == (q == QUIET), "R10", 32'(frm_done), 32'(q == QUIET));
    end
    chk(rssi == h2, "R10", 32'(rssi), 32'(h2));
    chk(lqi == h1, "R10", 32'(lqi), 32'(h1));
    chk(rx_err == h0[4:0], "R10", 32'(rx_err), 32'(h0[4:0]));
    chk(frm_aborted == 1'b1, "R11", 32'(frm_aborted), 1);
    rx_en = 1'b1;
    idle_check("R8");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    h0 = '0; h1 = '0; h2 = '0;
    repeat (3) @(negedge clk);
    chk(frm_done == 1'b0 && pay_stb == 1'b0, "R1", 32'({frm_done, pay_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_len == 0 && frm_rate == 0 && hdr_err == 0, "R1", 32'(frm_len), 0);
    chk(rssi == 0 && lqi == 0 && rx_err == 0 && frm_aborted == 0, "R1", 32'(rssi), 0);
    // directed corner cases
    send_frame(0, 0);      // R7
    send_frame(1, 1);
    send_frame(300, 0);    // R3 high nibble
    // rx_en low outside a frame is ignored (R9)
    rx_en = 1'b0;
    repeat (5) idle_check("R9");
    rx_en = 1'b1;
    send_frame(3, 0);
    send_abort(40, 25, 3, 1'b0);
    send_abort(10, 5, 0, 1'b0);
    send_abort(20, 30, 2, 1'b1);
    send_frame(0, 2);
    // random frames
    for (int n = 0; n < 30; n++) send_frame(int'($urandom % 48), int'($urandom % 3));
    send_abort(12, 18, 1, 1'b0);
    send_frame(7, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule